// File: doc/BRIEF.md
# UART Receiver with Character Error Classification

This block receives asynchronous serial characters and gives every completed character a status. The serial line passes through a synchronizer. The receiver runs from a 16x oversampling clock enable and takes three samples around the middle of each bit. It builds a character of 5 to 8 data bits, least significant bit first, with an optional parity bit after the data bits. When the stop bit ends, it reports the character on a one-cycle strobe together with a set of error flags.

Each error class has a fixed rule. The rule decides whether the character is delivered, whether the surrounding buffer should be closed, whether a receive interrupt is raised, and whether a saturating error counter advances. Loss of carrier while carrier control is enabled overrides every other check. A missing stop bit suppresses the parity check. A noisy bit is reported, but reception carries on. In multidrop operation, every error that closes the buffer also asks the receiver to return to address hunting. In synchronous operation with zero stop bits allowed, a low stop slot is still reported as a framing error, and it is then taken as the start bit of the next character.

Descriptor memory and data movement belong to the surrounding logic. This block only produces the strobes and requests that the surrounding logic acts on.

Top module: `uart_rx_classifier`

## Requirements
- R1: Each bit is sampled on oversampling ticks 7, 8 and 9 of the bit, counted from 0. The bit value is the majority of the three samples, so a single-sample glitch does not change the delivered data.
- R2: If the three samples of any bit of a character disagree, `err_noise` is set with `char_valid`. The buffer is not closed for noise alone, and `noise_cnt` advances by one.
- R3: While `sync_mode` is 1, `err_noise` stays 0 and `noise_cnt` does not advance.
- R4: If `carrier_ok` falls during a character while `carrier_ctl_en` is 1, the character is discarded: `char_valid` stays 0 and `char_data` keeps its value. `err_carrier`, `buf_close` and the interrupt are raised, and all other error flags stay 0. If `carrier_ctl_en` is 0, a carrier drop has no effect.
- R5: `par_mode` 2'b01 selects even parity and 2'b10 selects odd parity; 2'b00 and 2'b11 select no parity bit. On a parity mismatch, the character is delivered with `err_parity`, the buffer is closed, the interrupt is raised and `par_cnt` advances.
- R6: A stop bit sampled as 0 gives `err_framing`. The character is delivered, the buffer is closed, the interrupt is raised and `frm_cnt` advances. `err_parity` is 0 for that character even if its parity is wrong.
- R7: If a character completes while the previous one has not been taken through `char_taken`, the new character is delivered with `err_overrun` and the buffer is closed.
- R8: When `multidrop` is 1, `hunt_req` pulses with every status that closes the buffer, and at no other time.
- R9: With `sync_mode` and `zero_stop_ok` both at 1, a low stop slot is reported as a framing error. That slot then counts as the start bit of the next character, which is received without any idle time in between.
- R10: `rx_irq` pulses exactly when `buf_close` pulses and `irq_mask` is 0.
- R11: The three error counters saturate at all ones. Each counter returns to 0 when its own clear input is raised.
- R12: A clean character is delivered LSB first on a one-cycle `char_valid`, with all error flags at 0 and no buffer close.
- R13: After reset all strobes, flags and counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | 16x oversampling clock enable |
| rx_line | input | 1 | Serial receive line, idle high |
| carrier_ok | input | 1 | Carrier present (1) |
| carrier_ctl_en | input | 1 | Abort reception on carrier loss |
| par_mode | input | 2 | 01 even, 10 odd, otherwise none |
| multidrop | input | 1 | Request hunt on closing errors |
| sync_mode | input | 1 | Synchronous mode: no noise reports |
| zero_stop_ok | input | 1 | Continue after a low stop slot in synchronous mode |
| irq_mask | input | 1 | Masks the receive interrupt |
| char_taken | input | 1 | Consumer took the delivered character |
| clr_par_cnt | input | 1 | Clear parity error counter |
| clr_frm_cnt | input | 1 | Clear framing error counter |
| clr_noise_cnt | input | 1 | Clear noise error counter |
| char_valid | output | 1 | Character delivered (one cycle) |
| char_data | output | DATA_BITS | Last delivered character |
| err_overrun | output | 1 | Overrun status |
| err_carrier | output | 1 | Carrier lost status |
| err_parity | output | 1 | Parity error status |
| err_framing | output | 1 | Framing error status |
| err_noise | output | 1 | Noise status |
| buf_close | output | 1 | Buffer close request (one cycle) |
| rx_irq | output | 1 | Receive interrupt request (one cycle) |
| par_cnt | output | CNT_W | Parity error count |
| frm_cnt | output | CNT_W | Framing error count |
| noise_cnt | output | CNT_W | Noise error count |
| hunt_req | output | 1 | Return-to-hunt request (one cycle) |

## Verification
The bound checker checks the per-status rules on every cycle:
- a carrier-loss status excludes delivery and every other flag;
- a framing error never carries a parity flag;
- noise alone never closes the buffer;
- noise is never reported in synchronous mode;
- the interrupt and hunt requests follow buffer close, the mask and multidrop;
- the counters stay at all ones once saturated.

Only the bench scenarios can show that data is rebuilt correctly from the line, LSB first, and that majority voting removes a glitch. They also show that both parity senses are judged correctly across a sweep of data values, and that an overrun appears only when the consumer failed to take a character. Finally, they show that the zero-stop continuation delivers the following character with no idle gap.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP,
      ST_WAITHI
   } rx_state_e;

   typedef struct packed {
      logic ovr;
      logic cdl;
      logic par;
      logic frm;
      logic noi;
   } rx_err_t;

   localparam logic [1:0] PM_EVEN = 2'b01;
   localparam logic [1:0] PM_ODD  = 2'b10;

   function automatic logic vote3(input logic [2:0] s);
      return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
   endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
   parameter int          STAGES = 2,
   parameter int          W      = 2,
   parameter logic [W-1:0] RST   = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 1) begin : g_bad_stages
      $error("uart_rx_sync: STAGES must be at least 1");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= RST;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= RST;
            else        chain[g] <= chain[g-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_bitsampler.sv
module uart_rx_bitsampler
   import uart_rx_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic run,
   input  logic rxd,
   output logic bit_end,
   output logic bit_val,
   output logic bit_noisy
);
   localparam int CW  = $clog2(OVS);
   localparam int MID = OVS / 2;

   if (OVS < 8 || OVS > 64) begin : g_bad_ovs
      $error("uart_rx_bitsampler: OVS must lie in 8..64");
   end

   logic [CW-1:0] cnt;
   logic [2:0]    smp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         smp <= '0;
      end else if (!run) begin
         cnt <= '0;
      end else if (tick) begin
         cnt <= (cnt == CW'(OVS - 1)) ? '0 : cnt + 1'b1;
         if (cnt == CW'(MID - 1)) smp[0] <= rxd;
         if (cnt == CW'(MID))     smp[1] <= rxd;
         if (cnt == CW'(MID + 1)) smp[2] <= rxd;
      end
   end

   assign bit_end   = run & tick & (cnt == CW'(OVS - 1));
   assign bit_val   = vote3(smp);
   assign bit_noisy = (|smp) & ~(&smp);
endmodule

// File: rtl/uart_rx_errcnt.sv
module uart_rx_errcnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   if (W < 1) begin : g_bad_w
      $error("uart_rx_errcnt: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (clr)               cnt <= '0;
      else if (inc && !(&cnt))    cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/uart_rx_classifier.sv
module uart_rx_classifier
   import uart_rx_pkg::*;
#(
   parameter int DATA_BITS   = 8,
   parameter int OVS         = 16,
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 os_tick,
   input  logic                 rx_line,
   input  logic                 carrier_ok,
   input  logic                 carrier_ctl_en,
   input  logic [1:0]           par_mode,
   input  logic                 multidrop,
   input  logic                 sync_mode,
   input  logic                 zero_stop_ok,
   input  logic                 irq_mask,
   input  logic                 char_taken,
   input  logic                 clr_par_cnt,
   input  logic                 clr_frm_cnt,
   input  logic                 clr_noise_cnt,
   output logic                 char_valid,
   output logic [DATA_BITS-1:0] char_data,
   output logic                 err_overrun,
   output logic                 err_carrier,
   output logic                 err_parity,
   output logic                 err_framing,
   output logic                 err_noise,
   output logic                 buf_close,
   output logic                 rx_irq,
   output logic [CNT_W-1:0]     par_cnt,
   output logic [CNT_W-1:0]     frm_cnt,
   output logic [CNT_W-1:0]     noise_cnt,
   output logic                 hunt_req
);
   localparam int BCW = $clog2(DATA_BITS);
   localparam int NCNT = 3;

   if (DATA_BITS < 5 || DATA_BITS > 8) begin : g_bad_db
      $error("uart_rx_classifier: DATA_BITS must lie in 5..8");
   end

   // line and carrier synchronizer
   logic [1:0] sync_q;
   logic       rxd_s, cd_s;

   uart_rx_sync #(.STAGES(SYNC_STAGES), .W(2), .RST(2'b11)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({rx_line, carrier_ok}),
      .q     (sync_q)
   );
   assign rxd_s = sync_q[1];
   assign cd_s  = sync_q[0];

   // bit sampler
   rx_state_e state;
   logic      run, bit_end, bit_val, bit_noisy;

   assign run = (state == ST_START) || (state == ST_DATA) ||
                (state == ST_PAR)   || (state == ST_STOP);

   uart_rx_bitsampler #(.OVS(OVS)) u_bits (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (os_tick),
      .run       (run),
      .rxd       (rxd_s),
      .bit_end   (bit_end),
      .bit_val   (bit_val),
      .bit_noisy (bit_noisy)
   );

   // character assembly and classification
   logic [BCW-1:0]       bitcnt;
   logic [DATA_BITS-1:0] shreg;
   logic                 par_acc, par_bit, noise_acc, pending;
   logic                 par_en, cd_abort;
   rx_err_t              err_now, err_q;
   logic                 close_now;
   logic                 valid_q, close_q, irq_q, hunt_q;
   logic [DATA_BITS-1:0] data_q;

   assign par_en   = (par_mode == PM_EVEN) || (par_mode == PM_ODD);
   assign cd_abort = run && carrier_ctl_en && !cd_s;

   always_comb begin
      err_now     = '0;
      err_now.frm = ~bit_val;
      err_now.noi = (noise_acc | bit_noisy) & ~sync_mode;
      err_now.par = par_en & bit_val & ((par_acc ^ par_bit) != (par_mode == PM_ODD));
      err_now.ovr = pending & ~char_taken;
      close_now   = err_now.frm | err_now.par | err_now.ovr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         bitcnt    <= '0;
         shreg     <= '0;
         par_acc   <= 1'b0;
         par_bit   <= 1'b0;
         noise_acc <= 1'b0;
         pending   <= 1'b0;
         err_q     <= '0;
         valid_q   <= 1'b0;
         close_q   <= 1'b0;
         irq_q     <= 1'b0;
         hunt_q    <= 1'b0;
         data_q    <= '0;
      end else begin
         valid_q <= 1'b0;
         err_q   <= '0;
         close_q <= 1'b0;
         irq_q   <= 1'b0;
         hunt_q  <= 1'b0;
         if (char_taken) pending <= 1'b0;

         if (cd_abort) begin
            state     <= ST_WAITHI;
            err_q.cdl <= 1'b1;
            close_q   <= 1'b1;
            irq_q     <= ~irq_mask;
            hunt_q    <= multidrop;
         end else begin
            unique case (state)
               ST_IDLE: begin
                  if (os_tick && !rxd_s) state <= ST_START;
               end
               ST_START: begin
                  if (bit_end) begin
                     if (bit_val) begin
                        state <= ST_IDLE;
                     end else begin
                        state     <= ST_DATA;
                        bitcnt    <= '0;
                        par_acc   <= 1'b0;
                        noise_acc <= bit_noisy;
                     end
                  end
               end
               ST_DATA: begin
                  if (bit_end) begin
                     shreg     <= {bit_val, shreg[DATA_BITS-1:1]};
                     par_acc   <= par_acc ^ bit_val;
                     noise_acc <= noise_acc | bit_noisy;
                     if (bitcnt == BCW'(DATA_BITS - 1)) state <= par_en ? ST_PAR : ST_STOP;
                     else                               bitcnt <= bitcnt + 1'b1;
                  end
               end
               ST_PAR: begin
                  if (bit_end) begin
                     par_bit   <= bit_val;
                     noise_acc <= noise_acc | bit_noisy;
                     state     <= ST_STOP;
                  end
               end
               ST_STOP: begin
                  if (bit_end) begin
                     valid_q <= 1'b1;
                     data_q  <= shreg;
                     err_q   <= err_now;
                     close_q <= close_now;
                     irq_q   <= close_now & ~irq_mask;
                     hunt_q  <= close_now & multidrop;
                     pending <= 1'b1;
                     if (!bit_val && sync_mode && zero_stop_ok) begin
                        state     <= ST_DATA;
                        bitcnt    <= '0;
                        par_acc   <= 1'b0;
                        noise_acc <= 1'b0;
                     end else if (!bit_val) begin
                        state <= ST_WAITHI;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               ST_WAITHI: begin
                  if (os_tick && rxd_s) state <= ST_IDLE;
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   // saturating error counters: 0 parity, 1 framing, 2 noise
   logic [NCNT-1:0]  cnt_inc, cnt_clr;
   logic [CNT_W-1:0] cnt_val [NCNT];

   assign cnt_inc = {err_q.noi, err_q.frm, err_q.par};
   assign cnt_clr = {clr_noise_cnt, clr_frm_cnt, clr_par_cnt};

   for (genvar g = 0; g < NCNT; g++) begin : g_cnt
      uart_rx_errcnt #(.W(CNT_W)) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (cnt_clr[g]),
         .inc   (cnt_inc[g]),
         .cnt   (cnt_val[g])
      );
   end

   assign par_cnt     = cnt_val[0];
   assign frm_cnt     = cnt_val[1];
   assign noise_cnt   = cnt_val[2];
   assign char_valid  = valid_q;
   assign char_data   = data_q;
   assign err_overrun = err_q.ovr;
   assign err_carrier = err_q.cdl;
   assign err_parity  = err_q.par;
   assign err_framing = err_q.frm;
   assign err_noise   = err_q.noi;
   assign buf_close   = close_q;
   assign rx_irq      = irq_q;
   assign hunt_req    = hunt_q;
endmodule

// File: rtl/uart_rx_classifier_chk.sv
module uart_rx_classifier_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sync_mode,
   input logic             multidrop,
   input logic             irq_mask,
   input logic             clr_par_cnt,
   input logic             char_valid,
   input logic             err_overrun,
   input logic             err_carrier,
   input logic             err_parity,
   input logic             err_framing,
   input logic             err_noise,
   input logic             buf_close,
   input logic             rx_irq,
   input logic             hunt_req,
   input logic [CNT_W-1:0] par_cnt
);
   // R4: carrier loss stands alone and closes the buffer
   p_cd_alone_r4: assert property (@(posedge clk) disable iff (!rst_n)
      err_carrier |-> (!char_valid && !err_overrun && !err_parity &&
                       !err_framing && !err_noise && buf_close));

   // R6: framing error suppresses the parity verdict
   p_frm_no_par_r6: assert property (@(posedge clk) disable iff (!rst_n)
      err_framing |-> !err_parity);

   // R2: noise by itself never closes the buffer
   p_noise_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (char_valid && err_noise && !err_parity && !err_framing && !err_overrun) |-> !buf_close);

   // R3: no noise report in synchronous mode
   p_sync_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      err_noise |-> !$past(sync_mode));

   // R10: interrupt follows buffer close and mask
   p_irq_needs_close_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> buf_close);
   p_irq_unmasked_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_close && !$past(irq_mask)) |-> rx_irq);

   // R8: hunt request only with a close in multidrop mode
   p_hunt_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hunt_req |-> (buf_close && $past(multidrop)));

   // R11: saturated counter holds without a clear
   p_par_sat_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ((&par_cnt) && !clr_par_cnt) |=> (&par_cnt));
endmodule

bind uart_rx_classifier uart_rx_classifier_chk #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sync_mode   (sync_mode),
   .multidrop   (multidrop),
   .irq_mask    (irq_mask),
   .clr_par_cnt (clr_par_cnt),
   .char_valid  (char_valid),
   .err_overrun (err_overrun),
   .err_carrier (err_carrier),
   .err_parity  (err_parity),
   .err_framing (err_framing),
   .err_noise   (err_noise),
   .buf_close   (buf_close),
   .rx_irq      (rx_irq),
   .hunt_req    (hunt_req),
   .par_cnt     (par_cnt)
);

// File: tb/uart_rx_classifier_bench.sv
module uart_rx_classifier_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DB  = 8;
   localparam int CW  = 3;
   localparam int OVS = 16;
   localparam int CMAX = (1 << CW) - 1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic os_tick = 1'b1, rx_line = 1'b1, carrier_ok = 1'b1, carrier_ctl_en = 1'b0;
   logic [1:0] par_mode = 2'b00;
   logic multidrop = 0, sync_mode = 0, zero_stop_ok = 0, irq_mask = 0, char_taken = 0;
   logic clr_par_cnt = 0, clr_frm_cnt = 0, clr_noise_cnt = 0;
   logic char_valid, err_overrun, err_carrier, err_parity, err_framing, err_noise;
   logic buf_close, rx_irq, hunt_req;
   logic [DB-1:0] char_data;
   logic [CW-1:0] par_cnt, frm_cnt, noise_cnt;

   uart_rx_classifier #(.DATA_BITS(DB), .OVS(OVS), .CNT_W(CW), .SYNC_STAGES(2)) u_uart_rx_classifier (
      .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_line(rx_line),
      .carrier_ok(carrier_ok), .carrier_ctl_en(carrier_ctl_en), .par_mode(par_mode),
      .multidrop(multidrop), .sync_mode(sync_mode), .zero_stop_ok(zero_stop_ok),
      .irq_mask(irq_mask), .char_taken(char_taken), .clr_par_cnt(clr_par_cnt),
      .clr_frm_cnt(clr_frm_cnt), .clr_noise_cnt(clr_noise_cnt),
      .char_valid(char_valid), .char_data(char_data), .err_overrun(err_overrun),
      .err_carrier(err_carrier), .err_parity(err_parity), .err_framing(err_framing),
      .err_noise(err_noise), .buf_close(buf_close), .rx_irq(rx_irq),
      .par_cnt(par_cnt), .frm_cnt(frm_cnt), .noise_cnt(noise_cnt), .hunt_req(hunt_req)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   // status record: v cdl ovr par frm noi cls irq hunt data
   typedef struct packed {
      logic v, cdl, ovr, par, frm, noi, cls, irq, hunt;
      logic [DB-1:0] d;
   } ev_t;

   ev_t evq [0:7];
   int  ev_n = 0;
   int  ev_base = 0;
   int  vectors = 0, fails = 0;
   int  exp_par = 0, exp_frm = 0, exp_noi = 0;

   always @(negedge clk) begin
      if (rst_n && (char_valid || err_carrier)) begin
         evq[ev_n % 8] <= {char_valid, err_carrier, err_overrun, err_parity, err_framing,
                           err_noise, buf_close, rx_irq, hunt_req, char_data};
         ev_n <= ev_n + 1;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic int sat(input int v);
      return (v > CMAX) ? CMAX : v;
   endfunction

   function automatic ev_t mkev(input bit v, cdl, ovr, par, frm, noi, cls, input [DB-1:0] d);
      ev_t e;
      e = {v, cdl, ovr, par, frm, noi, cls, cls & ~irq_mask, cls & multidrop, d};
      return e;
   endfunction

   function automatic logic [31:0] mkframe(input [DB-1:0] d, input int pm, input bit badpar,
                                           input bit stop, output int n);
      logic [31:0] lv = '1;
      lv[0] = 1'b0;
      for (int i = 0; i < DB; i++) lv[1+i] = d[i];
      n = DB + 1;
      if (pm == 1 || pm == 2) begin
         lv[n] = (^d) ^ (pm == 2) ^ badpar;
         n++;
      end
      lv[n] = stop;
      n++;
      return lv;
   endfunction

   task automatic send(input logic [31:0] lv, input int n, input int glitch_bit,
                       input int cd_bit, input bit take);
      ev_base = ev_n;
      for (int b = 0; b < n; b++) begin
         for (int s = 0; s < OVS; s++) begin
            @(negedge clk);
            rx_line = lv[b] ^ ((b == glitch_bit) && (s == 9));
            if (b == cd_bit && s == 4) carrier_ok = 1'b0;
         end
      end
      @(negedge clk);
      rx_line = 1'b1;
      carrier_ok = 1'b1;
      repeat (40) @(negedge clk);
      if (take) begin
         char_taken = 1'b1;
         @(negedge clk);
         char_taken = 1'b0;
      end
   endtask

   task automatic chk_ev(input int k, input ev_t e, input string tag);
      ev_t a;
      a = evq[(ev_base + k) % 8];
      check(a == e, tag, int'(a), int'(e));
   endtask

   task automatic chk_n(input int n, input string tag);
      check((ev_n - ev_base) == n, tag, ev_n - ev_base, n);
   endtask

   task automatic chk_cnt(input string tag);
      check({par_cnt, frm_cnt, noise_cnt} == {CW'(exp_par), CW'(exp_frm), CW'(exp_noi)}, tag,
            int'({par_cnt, frm_cnt, noise_cnt}), int'({CW'(exp_par), CW'(exp_frm), CW'(exp_noi)}));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      logic [31:0] lv, lv2;
      int n, n2;
      logic [DB-1:0] d;

      repeat (4) @(negedge clk);
      // R13: reset state
      check({char_valid, err_overrun, err_carrier, err_parity, err_framing, err_noise,
             buf_close, rx_irq, hunt_req, par_cnt, frm_cnt, noise_cnt} == '0, "R13 reset", 1, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check({char_valid, buf_close, rx_irq, par_cnt} == '0, "R13 after release", 1, 0);

      // R12 / R5: clean characters, sweep data and parity sense
      for (int pm = 0; pm < 4; pm++) begin
         par_mode = 2'(pm);
         for (int i = 0; i < 24; i++) begin
            d = DB'(i * 37 + 5);
            lv = mkframe(d, (pm == 3) ? 0 : pm, 1'b0, 1'b1, n);
            send(lv, n, -1, -1, 1'b1);
            chk_n(1, "R12 count");
            chk_ev(0, mkev(1, 0, 0, 0, 0, 0, 0, d), "R12 R5 clean char");
         end
      end
      chk_cnt("R12 counters idle");

      // R5 / R11: parity errors, counter saturation and clear
      for (int i = 0; i < 9; i++) begin
         par_mode = (i % 2 == 0) ? 2'b01 : 2'b10;
         d = DB'(i * 29 + 3);
         lv = mkframe(d, int'(par_mode), 1'b1, 1'b1, n);
         send(lv, n, -1, -1, 1'b1);
         exp_par = sat(exp_par + 1);
         chk_ev(0, mkev(1, 0, 0, 1, 0, 0, 1, d), "R5 parity error");
         chk_cnt("R11 parity count");
      end
      check(int'(par_cnt) == CMAX, "R11 saturated", int'(par_cnt), CMAX);
      @(negedge clk); clr_par_cnt = 1'b1;
      @(negedge clk); clr_par_cnt = 1'b0;
      @(negedge clk);
      exp_par = 0;
      chk_cnt("R11 clear");

      // R6: missing stop bit with wrong parity
      par_mode = 2'b01;
      lv = mkframe(8'h5A, 1, 1'b1, 1'b0, n);
      send(lv, n, -1, -1, 1'b1);
      exp_frm++;
      chk_ev(0, mkev(1, 0, 0, 0, 1, 0, 1, 8'h5A), "R6 framing");
      chk_cnt("R6 framing count");

      // R1 / R2: glitch on data bit 3 (frame bit 4)
      par_mode = 2'b00;
      lv = mkframe(8'hA5, 0, 1'b0, 1'b1, n);
      send(lv, n, 4, -1, 1'b1);
      exp_noi++;
      chk_ev(0, mkev(1, 0, 0, 0, 0, 1, 0, 8'hA5), "R1 R2 noise kept open");
      chk_cnt("R2 noise count");

      // R3: same glitch in synchronous mode
      sync_mode = 1'b1;
      send(lv, n, 4, -1, 1'b1);
      chk_ev(0, mkev(1, 0, 0, 0, 0, 0, 0, 8'hA5), "R3 no noise in sync");
      chk_cnt("R3 noise count held");
      sync_mode = 1'b0;

      // R4: carrier loss aborts; data output keeps 0xA5
      carrier_ctl_en = 1'b1;
      lv = mkframe(8'hFF, 0, 1'b0, 1'b1, n);
      send(lv, n, -1, 4, 1'b1);
      chk_n(1, "R4 abort count");
      chk_ev(0, mkev(0, 1, 0, 0, 0, 0, 1, 8'hA5), "R4 carrier lost");
      carrier_ctl_en = 1'b0;
      send(lv, n, -1, 4, 1'b1);
      chk_ev(0, mkev(1, 0, 0, 0, 0, 0, 0, 8'hFF), "R4 carrier ignored");

      // R7: overrun when first character not taken
      lv = mkframe(8'h11, 0, 1'b0, 1'b1, n);
      send(lv, n, -1, -1, 1'b0);
      chk_ev(0, mkev(1, 0, 0, 0, 0, 0, 0, 8'h11), "R7 first char");
      lv = mkframe(8'h22, 0, 1'b0, 1'b1, n);
      send(lv, n, -1, -1, 1'b1);
      chk_ev(0, mkev(1, 0, 1, 0, 0, 0, 1, 8'h22), "R7 overrun");

      // R8: hunt request in multidrop mode
      multidrop = 1'b1;
      lv = mkframe(8'h33, 0, 1'b0, 1'b1, n);
      send(lv, n, -1, -1, 1'b1);
      chk_ev(0, mkev(1, 0, 0, 0, 0, 0, 0, 8'h33), "R8 no hunt when clean");
      par_mode = 2'b10;
      lv = mkframe(8'h44, 2, 1'b1, 1'b1, n);
      send(lv, n, -1, -1, 1'b1);
      exp_par++;
      chk_ev(0, mkev(1, 0, 0, 1, 0, 0, 1, 8'h44), "R8 hunt on parity");
      multidrop = 1'b0;

      // R10: masked interrupt
      irq_mask = 1'b1;
      send(lv, n, -1, -1, 1'b1);
      exp_par++;
      chk_ev(0, mkev(1, 0, 0, 1, 0, 0, 1, 8'h44), "R10 irq masked");
      irq_mask = 1'b0;
      chk_cnt("R10 counters");

      // R9: zero stop continuation in synchronous mode
      par_mode = 2'b00;
      sync_mode = 1'b1;
      zero_stop_ok = 1'b1;
      lv = mkframe(8'h3C, 0, 1'b0, 1'b0, n);
      lv2 = mkframe(8'h96, 0, 1'b0, 1'b1, n2);
      for (int i = 1; i < n2; i++) lv[n + i - 1] = lv2[i];
      char_taken = 1'b1;
      send(lv, n + n2 - 1, -1, -1, 1'b0);
      char_taken = 1'b0;
      exp_frm++;
      chk_n(2, "R9 two characters");
      chk_ev(0, mkev(1, 0, 0, 0, 1, 0, 1, 8'h3C), "R9 framing reported");
      chk_ev(1, mkev(1, 0, 0, 0, 0, 0, 0, 8'h96), "R9 next char");
      chk_cnt("R9 counters");
      sync_mode = 1'b0;
      zero_stop_ok = 1'b0;

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule